// File: doc/BRIEF.md
# Clock Reconfiguration Control Registers

This block is the register front end of a clock synthesizer's dynamic reconfiguration path. A host issues 32-bit reads and writes over a single-cycle request/response bus with a 12-bit byte address. The block holds a bank of staged divider words and copies them into a working set when software starts a reload. It then raises a start request to the reconfiguration sequencer and keeps the load bit set until the sequencer finishes and the synthesizer has locked again.

The block also presents lock status and the clock monitor's error flags. It latches enabled monitor events into write-1-to-clear interrupt status and drives one combined interrupt line. A keyed software reset returns all of it to the power-up state. The sequencer reads the working set through a separate index/word port, so the working words stay fixed for the whole of a reconfiguration.

Top module: `clkcfg_regs`

## Requirements
- R1: After reset, interrupt status (0x00C), interrupt enable (0x010), control (0x014) and every divider word read 0. The working set reads 0 on `cfg_word`, and `irq` and `seq_start` are 0.
- R2: A write of exactly 0x0000000A to offset 0x000 restores every register to its reset value at the second clock edge after the write, and abandons a pending load. A write of any other value to 0x000 has no effect. Reads of 0x000 return 0.
- R3: Offset 0x004 bit 0 reads `pll_locked`, except that it reads 0 whenever the load bit is 1.
- R4: Offset 0x008 returns `mon_err` as registered one clock earlier, zero-extended.
- R5: A pulse on `mon_evt` bit i sets status bit i at 0x00C only if enable bit i at 0x010 is 1. The bits are 0 clock stop, 1 overrun and 2 underrun.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an enabled event on the same bit arrives in the same cycle as the clear, the bit stays 1.
- R7: `irq` is 1 exactly when some status bit and its enable bit are both 1. Clearing the enable drops `irq` while the status bit is kept.
- R8: A write to 0x014 with bit 0 = 1 while the load bit is 0 sets the load bit, pulses `seq_start` for exactly one cycle and loads the working set in that same edge.
- R9: Bit 1 of that write selects the source and is kept in 0x014 bit 1. With 1 the working word i is copied from staged word i. With 0 the working word for offset A is 0x00C30000 OR A.
- R10: The load bit stays 1 until `seq_done` has been seen and `pll_locked` is 1. It clears in the edge where both hold, which may be the same edge as `seq_done`.
- R11: Word offsets 0x330 to 0x3FC hold 52 read/write divider words, where offset 0x330 + 4i is index i. While the load bit is 1, writes to these words and to 0x014 are ignored.
- R12: Offsets that are undefined or not word-aligned read 0, and writes to them change nothing.
- R13: Every request gets `rsp_valid` one clock later. The read data is taken from register values at the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| pll_locked | input | 1 | Synthesizer lock indication |
| seq_done | input | 1 | Sequencer finished pulse |
| seq_start | output | 1 | One-cycle start request to the sequencer |
| mon_err | input | 4 | Clock monitor error flags |
| mon_evt | input | 3 | Monitor event pulses: stop, overrun, underrun |
| irq | output | 1 | Combined interrupt |
| cfg_idx | input | 6 | Working-set word index for the sequencer |
| cfg_word | output | 32 | Working-set word at `cfg_idx` (0 if out of range) |

## Verification
Two pairs of functions meet in one cycle here. The first pair is a write-1-to-clear of a status bit and a new enabled event on that same bit. The bench drives both on the same clock edge and expects the bit to read 1 afterwards. A later plain clear must then read 0. The second pair is the sequencer's done pulse and lock. The bench raises `seq_done` while `pll_locked` is 1 and expects the load bit to read 0 on the next access. It also raises `seq_done` while lock is low and expects the load bit to stay 1 until lock returns.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int NUM_EVT = 3;

    localparam logic [ADDR_W-1:0] OFS_SRST = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_STAT = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_MERR = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_ISTS = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h014;
    localparam logic [ADDR_W-1:0] CFG_FIRST = 12'h330;

    localparam logic [DATA_W-1:0] SRST_KEY = 32'h0000_000A;
    localparam logic [DATA_W-1:0] DEF_TAG  = 32'h00C3_0000;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_SRST,
        REG_STAT,
        REG_MERR,
        REG_ISTS,
        REG_IEN,
        REG_CTRL,
        REG_CFG
    } reg_sel_e;

    typedef enum logic [1:0] {
        LD_IDLE,
        LD_WAIT_DONE,
        LD_WAIT_LOCK
    } ld_state_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    // Built-in setting for working word idx: tag ORed with its byte offset.
    function automatic logic [DATA_W-1:0] cfg_default(input int idx);
        logic [DATA_W-1:0] ofs;
        ofs = DATA_W'(CFG_FIRST) + DATA_W'(idx * 4);
        return DEF_TAG | ofs;
    endfunction

endpackage

// File: rtl/clkcfg_decode.sv
module clkcfg_decode
    import clkcfg_pkg::*;
#(
    parameter int NUM_CFG = 52,
    parameter int IDX_W   = $clog2(NUM_CFG)
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [IDX_W-1:0]  idx
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] CFG_CNT  = WORD_W'(NUM_CFG);
    localparam logic [WORD_W-1:0] CFG_WBASE = CFG_FIRST[ADDR_W-1:2];

    logic [WORD_W-1:0] word_rel;

    always_comb begin
        word_rel = addr[ADDR_W-1:2] - CFG_WBASE;
        idx      = word_rel[IDX_W-1:0];
        sel      = REG_NONE;
        if (addr[1:0] == 2'b00) begin
            case (addr)
                OFS_SRST: sel = REG_SRST;
                OFS_STAT: sel = REG_STAT;
                OFS_MERR: sel = REG_MERR;
                OFS_ISTS: sel = REG_ISTS;
                OFS_IEN:  sel = REG_IEN;
                OFS_CTRL: sel = REG_CTRL;
                default: begin
                    if (addr[ADDR_W-1:2] >= CFG_WBASE && word_rel < CFG_CNT)
                        sel = REG_CFG;
                end
            endcase
        end
    end

endmodule

// File: rtl/clkcfg_irq.sv
module clkcfg_irq
    import clkcfg_pkg::*;
#(
    parameter int N_EVT = NUM_EVT
) (
    input  logic             clk,
    input  logic             rst_all,
    input  logic             en_wr,
    input  logic             sts_wr,
    input  logic [N_EVT-1:0] wbits,
    input  logic [N_EVT-1:0] evt,
    output logic [N_EVT-1:0] sts,
    output logic [N_EVT-1:0] en,
    output logic             irq
);
    logic [N_EVT-1:0] clr_mask;
    logic [N_EVT-1:0] set_mask;

    always_comb begin
        clr_mask = sts_wr ? wbits : '0;
        set_mask = evt & en;
    end

    always_ff @(posedge clk) begin
        if (rst_all) begin
            sts <= '0;
            en  <= '0;
        end else begin
            if (en_wr) en <= wbits;
            // a new enabled event outranks a same-cycle clear
            sts <= (sts & ~clr_mask) | set_mask;
        end
    end

    assign irq = |(sts & en);

    for (genvar b = 0; b < N_EVT; b++) begin : g_chk
        a_r5_set_needs_enable: assert property (@(posedge clk) disable iff (rst_all)
            (!$past(sts[b]) && sts[b]) |-> $past(en[b] && evt[b]));

        a_r6_clear_wins_without_event: assert property (@(posedge clk) disable iff (rst_all)
            $past(sts_wr && wbits[b] && !(evt[b] && en[b])) |-> !sts[b]);
    end

endmodule

// File: rtl/clkcfg_ctrl.sv
module clkcfg_ctrl
    import clkcfg_pkg::*;
(
    input  logic clk,
    input  logic rst_all,
    input  logic ctrl_wr,
    input  logic wr_load,
    input  logic wr_src,
    input  logic seq_done,
    input  logic pll_locked,
    output logic load,
    output logic src,
    output logic seq_start,
    output logic copy_now
);
    ld_state_e state;

    always_ff @(posedge clk) begin
        if (rst_all) begin
            state     <= LD_IDLE;
            src       <= 1'b0;
            seq_start <= 1'b0;
        end else begin
            seq_start <= 1'b0;
            case (state)
                LD_IDLE: begin
                    if (ctrl_wr) begin
                        src <= wr_src;
                        if (wr_load) begin
                            state     <= LD_WAIT_DONE;
                            seq_start <= 1'b1;
                        end
                    end
                end
                LD_WAIT_DONE: begin
                    if (seq_done)
                        state <= pll_locked ? LD_IDLE : LD_WAIT_LOCK;
                end
                LD_WAIT_LOCK: begin
                    if (pll_locked) state <= LD_IDLE;
                end
                default: state <= LD_IDLE;
            endcase
        end
    end

    assign load     = (state != LD_IDLE);
    assign copy_now = ctrl_wr && wr_load && (state == LD_IDLE);

    a_r8_start_with_load: assert property (@(posedge clk) disable iff (rst_all)
        seq_start |-> load);

    a_r8_start_one_cycle: assert property (@(posedge clk) disable iff (rst_all)
        seq_start |=> !seq_start);

    a_r10_release_needs_lock: assert property (@(posedge clk) disable iff (rst_all)
        $fell(load) |-> ($past(pll_locked) || $past(rst_all)));

    a_r10_hold_until_done: assert property (@(posedge clk) disable iff (rst_all)
        (state == LD_WAIT_DONE && !seq_done) |=> load);

endmodule

// File: rtl/clkcfg_bank.sv
module clkcfg_bank
    import clkcfg_pkg::*;
#(
    parameter int NUM_CFG = 52,
    parameter int IDX_W   = $clog2(NUM_CFG)
) (
    input  logic              clk,
    input  logic              rst_all,
    input  logic              wr_en,
    input  logic              load,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_word,
    input  logic              copy_now,
    input  logic              copy_src,
    input  logic [IDX_W-1:0]  work_idx,
    output logic [DATA_W-1:0] work_word
);
    logic [DATA_W-1:0] stage_q [NUM_CFG];
    logic [DATA_W-1:0] work_q  [NUM_CFG];

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_word
        localparam logic [DATA_W-1:0] DEF_WORD = cfg_default(g);

        always_ff @(posedge clk) begin
            if (rst_all) begin
                stage_q[g] <= '0;
            end else if (wr_en && !load && wr_idx == IDX_W'(g)) begin
                stage_q[g] <= wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (rst_all) begin
                work_q[g] <= '0;
            end else if (copy_now) begin
                work_q[g] <= copy_src ? stage_q[g] : DEF_WORD;
            end
        end

        a_r11_working_frozen: assert property (@(posedge clk) disable iff (rst_all)
            (load && $past(load)) |-> $stable(work_q[g]));
    end

    always_comb begin
        rd_word = '0;
        if (int'(rd_idx) < NUM_CFG) rd_word = stage_q[rd_idx];
        work_word = '0;
        if (int'(work_idx) < NUM_CFG) work_word = work_q[work_idx];
    end

endmodule

// File: rtl/clkcfg_regs.sv
module clkcfg_regs
    import clkcfg_pkg::*;
#(
    parameter int NUM_CFG = 52,
    parameter int ERR_W   = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [DATA_W-1:0]          req_wdata,
    output logic                       rsp_valid,
    output logic [DATA_W-1:0]          rsp_rdata,
    input  logic                       pll_locked,
    input  logic                       seq_done,
    output logic                       seq_start,
    input  logic [ERR_W-1:0]           mon_err,
    input  logic [NUM_EVT-1:0]         mon_evt,
    output logic                       irq,
    input  logic [$clog2(NUM_CFG)-1:0] cfg_idx,
    output logic [DATA_W-1:0]          cfg_word
);
    localparam int IDX_W = $clog2(NUM_CFG);

    bus_req_t          req;
    reg_sel_e          sel;
    logic [IDX_W-1:0]  idx;
    logic              wr;
    logic              srst_q;
    logic              rst_all;
    logic [ERR_W-1:0]  err_q;
    logic [NUM_EVT-1:0] sts;
    logic [NUM_EVT-1:0] en;
    logic              load;
    logic              src;
    logic              copy_now;
    logic [DATA_W-1:0] bank_word;
    logic [DATA_W-1:0] rd_mux;

    assign req = '{valid: req_valid, write: req_write, addr: req_addr, wdata: req_wdata};
    assign wr  = req.valid && req.write;

    clkcfg_decode #(.NUM_CFG(NUM_CFG), .IDX_W(IDX_W)) u_dec (
        .addr (req.addr),
        .sel  (sel),
        .idx  (idx)
    );

    // keyed reset is registered, then acts for one edge on everything
    always_ff @(posedge clk) begin
        if (rst) srst_q <= 1'b0;
        else     srst_q <= wr && sel == REG_SRST && req.wdata == SRST_KEY;
    end
    assign rst_all = rst || srst_q;

    always_ff @(posedge clk) begin
        if (rst_all) err_q <= '0;
        else         err_q <= mon_err;
    end

    clkcfg_irq #(.N_EVT(NUM_EVT)) u_irq (
        .clk     (clk),
        .rst_all (rst_all),
        .en_wr   (wr && sel == REG_IEN),
        .sts_wr  (wr && sel == REG_ISTS),
        .wbits   (req.wdata[NUM_EVT-1:0]),
        .evt     (mon_evt),
        .sts     (sts),
        .en      (en),
        .irq     (irq)
    );

    clkcfg_ctrl u_ctrl (
        .clk        (clk),
        .rst_all    (rst_all),
        .ctrl_wr    (wr && sel == REG_CTRL),
        .wr_load    (req.wdata[0]),
        .wr_src     (req.wdata[1]),
        .seq_done   (seq_done),
        .pll_locked (pll_locked),
        .load       (load),
        .src        (src),
        .seq_start  (seq_start),
        .copy_now   (copy_now)
    );

    clkcfg_bank #(.NUM_CFG(NUM_CFG), .IDX_W(IDX_W)) u_bank (
        .clk       (clk),
        .rst_all   (rst_all),
        .wr_en     (wr && sel == REG_CFG),
        .load      (load),
        .wr_idx    (idx),
        .wdata     (req.wdata),
        .rd_idx    (idx),
        .rd_word   (bank_word),
        .copy_now  (copy_now),
        .copy_src  (req.wdata[1]),
        .work_idx  (cfg_idx),
        .work_word (cfg_word)
    );

    always_comb begin
        rd_mux = '0;
        case (sel)
            REG_STAT: rd_mux[0] = pll_locked && !load;
            REG_MERR: rd_mux = DATA_W'(err_q);
            REG_ISTS: rd_mux = DATA_W'(sts);
            REG_IEN:  rd_mux = DATA_W'(en);
            REG_CTRL: rd_mux[1:0] = {src, load};
            REG_CFG:  rd_mux = bank_word;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req.valid;
            rsp_rdata <= (req.valid && !req.write) ? rd_mux : '0;
        end
    end

    a_r13_response_follows: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid) |-> rsp_valid);

    a_r3_lock_hidden_while_busy: assert property (@(posedge clk) disable iff (rst)
        ($past(req_valid && !req_write && req_addr == OFS_STAT && load)) |-> !rsp_rdata[0]);

endmodule

// File: tb/clkcfg_regs_tb.sv
module clkcfg_regs_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        pll_locked = 1'b0;
    logic        seq_done = 1'b0;
    logic        seq_start;
    logic [3:0]  mon_err = '0;
    logic [2:0]  mon_evt = '0;
    logic        irq;
    logic [5:0]  cfg_idx = '0;
    logic [31:0] cfg_word;

    int total = 0;
    int bad = 0;
    logic [31:0] rd;

    always #5 clk = ~clk;

    clkcfg_regs u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .pll_locked(pll_locked), .seq_done(seq_done), .seq_start(seq_start),
        .mon_err(mon_err), .mon_evt(mon_evt), .irq(irq),
        .cfg_idx(cfg_idx), .cfg_word(cfg_word)
    );

    // {write, addr, wdata, expected read}
    localparam logic [76:0] VECS [16] = '{
        {1'b1, 12'h010, 32'h0000_0007, 32'h0},
        {1'b0, 12'h010, 32'h0,         32'h0000_0007},
        {1'b1, 12'h330, 32'h1111_2222, 32'h0},
        {1'b0, 12'h330, 32'h0,         32'h1111_2222},
        {1'b1, 12'h3FC, 32'hDEAD_BEEF, 32'h0},
        {1'b0, 12'h3FC, 32'h0,         32'hDEAD_BEEF},
        {1'b0, 12'h334, 32'h0,         32'h0},
        {1'b1, 12'h400, 32'h0000_0005, 32'h0},
        {1'b0, 12'h400, 32'h0,         32'h0},
        {1'b0, 12'h32C, 32'h0,         32'h0},
        {1'b0, 12'h332, 32'h0,         32'h0},
        {1'b1, 12'h000, 32'h0000_0005, 32'h0},
        {1'b0, 12'h010, 32'h0,         32'h0000_0007},
        {1'b0, 12'h000, 32'h0,         32'h0},
        {1'b1, 12'h3A0, 32'h0000_CAFE, 32'h0},
        {1'b0, 12'h3A0, 32'h0,         32'h0000_CAFE}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check("R13 rsp_valid", {31'b0, rsp_valid}, 32'h1);
        d = rsp_rdata;
    endtask

    task automatic pulse_evt(input logic [2:0] e);
        @(negedge clk);
        mon_evt = e;
        @(negedge clk);
        mon_evt = '0;
    endtask

    function automatic string tag_of(input logic [11:0] a);
        if (a[1:0] != 2'b00) return "R12";
        if (a >= 12'h330 && a <= 12'h3FC) return "R11";
        if (a > 12'h014) return "R12";
        return "R2";
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        #1;
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 seq_start", {31'b0, seq_start}, 32'h0);
        check("R1 cfg_word", cfg_word, 32'h0);
        bus_rd(12'h00C, rd); check("R1 ists", rd, 32'h0);
        bus_rd(12'h010, rd); check("R1 ien", rd, 32'h0);
        bus_rd(12'h014, rd); check("R1 ctrl", rd, 32'h0);
        bus_rd(12'h004, rd); check("R1 stat", rd, 32'h0);
        bus_rd(12'h330, rd); check("R1 cfg", rd, 32'h0);

        // table walk
        for (int i = 0; i < 16; i++) begin
            logic [76:0] v;
            v = VECS[i];
            if (v[76]) bus_wr(v[75:64], v[63:32]);
            else begin
                bus_rd(v[75:64], rd);
                check(tag_of(v[75:64]), rd, v[31:0]);
            end
        end

        // R4 monitor error flags
        mon_err = 4'h9;
        @(negedge clk);
        bus_rd(12'h008, rd); check("R4 merr", rd, 32'h9);
        mon_err = 4'h0;

        // R3 lock while idle
        pll_locked = 1'b1;
        bus_rd(12'h004, rd); check("R3 locked idle", rd, 32'h1);

        // R5 event gating
        bus_wr(12'h010, 32'h1);
        pulse_evt(3'b110);
        bus_rd(12'h00C, rd); check("R5 disabled events", rd, 32'h0);
        check("R7 irq quiet", {31'b0, irq}, 32'h0);
        pulse_evt(3'b001);
        bus_rd(12'h00C, rd); check("R5 enabled event", rd, 32'h1);
        check("R7 irq raised", {31'b0, irq}, 32'h1);

        // R6 clear and event collide on bit 0
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h00C; req_wdata = 32'h1;
        mon_evt = 3'b001;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; mon_evt = '0;
        bus_rd(12'h00C, rd); check("R6 event beats clear", rd, 32'h1);
        bus_wr(12'h00C, 32'h0);
        bus_rd(12'h00C, rd); check("R6 write zero keeps", rd, 32'h1);
        bus_wr(12'h00C, 32'h1);
        bus_rd(12'h00C, rd); check("R6 plain clear", rd, 32'h0);
        check("R7 irq after clear", {31'b0, irq}, 32'h0);

        // R7 enable masks output but keeps status
        bus_wr(12'h010, 32'h3);
        pulse_evt(3'b010);
        #1; check("R7 irq overrun", {31'b0, irq}, 32'h1);
        bus_wr(12'h010, 32'h1);
        #1; check("R7 irq masked", {31'b0, irq}, 32'h0);
        bus_rd(12'h00C, rd); check("R7 status kept", rd, 32'h2);

        // R8 / R9 load from staged words
        bus_wr(12'h330, 32'hAAAA_0001);
        bus_wr(12'h014, 32'h3);
        #1;
        check("R8 seq_start pulse", {31'b0, seq_start}, 32'h1);
        cfg_idx = 6'd0; #1;
        check("R9 staged copy idx0", cfg_word, 32'hAAAA_0001);
        cfg_idx = 6'd51; #1;
        check("R9 staged copy idx51", cfg_word, 32'hDEAD_BEEF);
        @(negedge clk); #1;
        check("R8 seq_start one cycle", {31'b0, seq_start}, 32'h0);
        bus_rd(12'h014, rd); check("R8 load set", rd, 32'h3);
        bus_rd(12'h004, rd); check("R3 hidden while busy", rd, 32'h0);

        // R11 writes ignored while busy
        bus_wr(12'h330, 32'h0000_0055);
        bus_rd(12'h330, rd); check("R11 staged frozen", rd, 32'hAAAA_0001);
        bus_wr(12'h014, 32'h0);
        bus_rd(12'h014, rd); check("R11 ctrl frozen", rd, 32'h3);
        cfg_idx = 6'd0; #1;
        check("R11 working frozen", cfg_word, 32'hAAAA_0001);

        // R10 done without lock, then lock
        pll_locked = 1'b0;
        @(negedge clk); seq_done = 1'b1;
        @(negedge clk); seq_done = 1'b0;
        bus_rd(12'h014, rd); check("R10 waits for lock", rd, 32'h3);
        pll_locked = 1'b1;
        @(negedge clk);
        bus_rd(12'h014, rd); check("R10 released", rd, 32'h2);
        bus_rd(12'h004, rd); check("R3 lock back", rd, 32'h1);

        // R9 defaults, R10 done and lock same edge
        bus_wr(12'h014, 32'h1);
        cfg_idx = 6'd0; #1;
        check("R9 default idx0", cfg_word, 32'h00C3_0330);
        cfg_idx = 6'd51; #1;
        check("R9 default idx51", cfg_word, 32'h00C3_03FC);
        @(negedge clk); seq_done = 1'b1;
        @(negedge clk); seq_done = 1'b0;
        bus_rd(12'h014, rd); check("R10 same edge release", rd, 32'h0);

        // R12 out-of-range working index
        cfg_idx = 6'd60; #1;
        check("R12 cfg_idx range", cfg_word, 32'h0);
        cfg_idx = 6'd0;

        // R2 keyed reset aborting a load
        bus_wr(12'h014, 32'h3);
        bus_wr(12'h000, 32'h0000_000A);
        @(negedge clk); #1;
        check("R2 seq_start", {31'b0, seq_start}, 32'h0);
        check("R2 working cleared", cfg_word, 32'h0);
        bus_rd(12'h014, rd); check("R2 ctrl cleared", rd, 32'h0);
        bus_rd(12'h010, rd); check("R2 ien cleared", rd, 32'h0);
        bus_rd(12'h00C, rd); check("R2 ists cleared", rd, 32'h0);
        bus_rd(12'h3FC, rd); check("R2 cfg cleared", rd, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule